// File: doc/BRIEF.md
# Zero-Crossing Phase Delay Timer

This block times the gap between rising zero crossings of a three-phase system. Six level inputs carry the sign of the three phase voltages and the three phase currents. A high level means the waveform is positive. The block finds the negative-to-positive transitions itself. Each of three timing channels starts on the crossing of its start signal. It reports the number of clock cycles until the next crossing of its stop signal, as a 16-bit unsigned count.

A 2-bit pairing select sets what the three channels measure. The choices are voltage-to-current lag on each phase, the spacing between the phase voltages, or the spacing between the phase currents. Only one set of three measurements is active at a time. Software or a downstream angle calculator reads the three results through a small registered read port. Turning counts into angles is left to that consumer.

Top module: `zx_delay_timer`

## Requirements
- R1: After reset, all three results read 0x0000.
- R2: With pairing 00, channel 0 times voltage A to current A, channel 1 voltage B to current B, and channel 2 voltage C to current C. The result equals the number of clock edges between the edge that samples the start crossing and the edge that samples the stop crossing.
- R3: With pairing 01, channel 0 times voltage A to voltage C, channel 1 voltage B to voltage C, and channel 2 voltage A to voltage B.
- R4: With pairing 10, channel 0 times current A to current C, channel 1 current B to current C, and channel 2 current A to current B.
- R5: Pairing 11 behaves exactly as pairing 00.
- R6: Only a low-to-high change of an input is a crossing. Falling transitions neither start nor stop a channel.
- R7: A measurement whose delay exceeds the count range reports 0xFFFF.
- R8: A new start crossing on a channel that is already timing restarts its count from zero.
- R9: A change of the effective pairing abandons every measurement in progress. Stored results keep their values until a later completed measurement overwrites them.
- R10: A stop crossing on a channel that is not timing has no effect on its result.
- R11: rd_data shows, one clock after rd_addr is presented, result 0, 1 or 2 for addresses 0, 1 and 2. Address 3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timing count clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_sel | input | 2 | Pairing select: 00 V-to-I, 01 V-to-V, 10 I-to-I, 11 as 00 |
| v_pos | input | 3 | Voltage sign levels, bit 0 phase A, bit 1 B, bit 2 C |
| i_pos | input | 3 | Current sign levels, bit 0 phase A, bit 1 B, bit 2 C |
| rd_addr | input | 2 | Result select |
| rd_data | output | 16 | Registered result read data |

## Verification
Most internal faults show up as a wrong count one clock after the stop crossing is sampled. Examples are a wrong edge detector, a swapped start/stop route, or an off-by-one increment. The fault is then visible on rd_data one clock after the matching address is presented. A channel that fails to abort or restart does not fail at once. It shows only when the later stop crossing arrives, because the stored value then moves when it should stay, or is longer than the last start allows. A counter that wraps instead of saturating shows only after 65535 cycles without a stop. That is why the saturation case runs past that length.

// File: rtl/zxd_pkg.sv
package zxd_pkg;
  localparam int NUM_PH = 3;

  typedef enum logic [1:0] {
    PAIR_VI = 2'b00,
    PAIR_VV = 2'b01,
    PAIR_II = 2'b10
  } pair_mode_e;
endpackage

// File: rtl/zxd_edge.sv
module zxd_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      rise  <= '0;
    end else begin
      lvl_q <= lvl;
      rise  <= lvl & ~lvl_q;
    end
  end

  // a crossing pulse lasts a single cycle
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0)); // R6
endmodule

// File: rtl/zxd_route.sv
module zxd_route
  import zxd_pkg::*;
(
  input  pair_mode_e        mode,
  input  logic [NUM_PH-1:0] v_rise,
  input  logic [NUM_PH-1:0] i_rise,
  output logic [NUM_PH-1:0] start,
  output logic [NUM_PH-1:0] stop
);
  always_comb begin
    start = v_rise;
    stop  = i_rise;
    case (mode)
      PAIR_VV: begin
        start[0] = v_rise[0]; stop[0] = v_rise[2];
        start[1] = v_rise[1]; stop[1] = v_rise[2];
        start[2] = v_rise[0]; stop[2] = v_rise[1];
      end
      PAIR_II: begin
        start[0] = i_rise[0]; stop[0] = i_rise[2];
        start[1] = i_rise[1]; stop[1] = i_rise[2];
        start[2] = i_rise[0]; stop[2] = i_rise[1];
      end
      default: begin
        start = v_rise;
        stop  = i_rise;
      end
    endcase
  end
endmodule

// File: rtl/zxd_channel.sv
module zxd_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic             stop,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else if (abort) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (stop) begin
        result <= cnt_next;
        active <= 1'b0;
      end else begin
        cnt <= cnt_next;
      end
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == CNT_MAX && !abort && !start && !stop) |=> (cnt == CNT_MAX)); // R7
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (start && !abort) |=> (active && cnt == '0)); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> !active); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(active && stop && !start && !abort) |=> $stable(result)); // R10
endmodule

// File: rtl/zx_delay_timer.sv
module zx_delay_timer
  import zxd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pair_sel,
  input  logic [NUM_PH-1:0] v_pos,
  input  logic [NUM_PH-1:0] i_pos,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int NSIG = 2 * NUM_PH;

  logic [NSIG-1:0]   rise;
  logic [NUM_PH-1:0] start, stop;
  pair_mode_e        mode_eff, mode_q;
  logic              abort;
  logic [CNT_W-1:0]  res [NUM_PH];
  logic [CNT_W-1:0]  rd_sel;

  zxd_edge #(.N(NSIG)) edge_i (
    .clk (clk),
    .rst (rst),
    .lvl ({i_pos, v_pos}),
    .rise(rise)
  );

  always_comb begin
    case (pair_sel)
      2'b01:   mode_eff = PAIR_VV;
      2'b10:   mode_eff = PAIR_II;
      default: mode_eff = PAIR_VI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PAIR_VI;
    else     mode_q <= mode_eff;
  end

  assign abort = (mode_eff != mode_q);

  zxd_route route_i (
    .mode  (mode_q),
    .v_rise(rise[NUM_PH-1:0]),
    .i_rise(rise[NSIG-1:NUM_PH]),
    .start (start),
    .stop  (stop)
  );

  for (genvar c = 0; c < NUM_PH; c++) begin : g_ch
    zxd_channel #(.CNT_W(CNT_W)) ch_i (
      .clk   (clk),
      .rst   (rst),
      .abort (abort),
      .start (start[c]),
      .stop  (stop[c]),
      .result(res[c])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NUM_PH; k++)
      if (rd_addr == ADDR_W'(k)) rd_sel = res[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel;
  end

  AST_RD_UNUSED: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= ADDR_W'(NUM_PH)) |=> (rd_data == '0)); // R11
  AST_MODE_Q_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    abort |=> (mode_q == $past(mode_eff))); // R9
endmodule

// File: tb/zx_delay_timer_tb_top.sv
`timescale 1ns/1ps
module zx_delay_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pair_sel = 2'b00;
  logic [2:0]  v_pos = '0;
  logic [2:0]  i_pos = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zx_delay_timer dut_i (
    .clk(clk), .rst(rst), .pair_sel(pair_sel),
    .v_pos(v_pos), .i_pos(i_pos),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic rd_chk(input int addr, input int exp, input string req);
    rd_addr = addr[1:0];
    @(negedge clk);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise each signal at its own offset (-1 = never), then lower all
  task automatic run_pat(input int va, input int vb, input int vc,
                         input int ia, input int ib, input int ic);
    int tm[6];
    int last;
    tm = '{va, vb, vc, ia, ib, ic};
    last = 0;
    for (int s = 0; s < 6; s++) if (tm[s] > last) last = tm[s];
    for (int t = 0; t <= last; t++) begin
      for (int s = 0; s < 3; s++) if (tm[s] == t) v_pos[s] = 1'b1;
      for (int s = 0; s < 3; s++) if (tm[s+3] == t) i_pos[s] = 1'b1;
      @(negedge clk);
    end
    idle(4);
    v_pos = '0;
    i_pos = '0;
    idle(3);
  endtask

  task automatic set_mode(input logic [1:0] m);
    pair_sel = m;
    idle(3);
  endtask

  initial begin
    int lst[3];
    int dl[4];
    int r0;
    lst = '{1, 4, 19};
    dl  = '{1, 2, 9, 33};
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state, R11 unused address
    for (int a = 0; a < 3; a++) rd_chk(a, 0, "R1 reset result");
    rd_chk(3, 0, "R11 address 3");

    // R2 voltage-to-current sweep
    set_mode(2'b00);
    foreach (lst[x]) foreach (lst[y]) foreach (lst[z]) begin
      run_pat(0, 0, 0, lst[x], lst[y], lst[z]);
      rd_chk(0, lst[x], "R2 ch0 VA->IA");
      rd_chk(1, lst[y], "R2 ch1 VB->IB");
      rd_chk(2, lst[z], "R2 ch2 VC->IC");
    end

    // R3 voltage-to-voltage sweep
    set_mode(2'b01);
    foreach (dl[x]) foreach (dl[y]) begin
      run_pat(0, dl[x], dl[x] + dl[y], -1, -1, -1);
      rd_chk(0, dl[x] + dl[y], "R3 ch0 VA->VC");
      rd_chk(1, dl[y], "R3 ch1 VB->VC");
      rd_chk(2, dl[x], "R3 ch2 VA->VB");
    end

    // R4 current-to-current sweep
    set_mode(2'b10);
    foreach (dl[x]) foreach (dl[y]) begin
      run_pat(-1, -1, -1, 0, dl[x], dl[x] + dl[y]);
      rd_chk(0, dl[x] + dl[y], "R4 ch0 IA->IC");
      rd_chk(1, dl[y], "R4 ch1 IB->IC");
      rd_chk(2, dl[x], "R4 ch2 IA->IB");
    end

    // R5 reserved code acts as voltage-to-current
    set_mode(2'b11);
    run_pat(0, 0, 0, 6, 11, 3);
    rd_chk(0, 6, "R5 ch0");
    rd_chk(1, 11, "R5 ch1");
    rd_chk(2, 3, "R5 ch2");

    // R10 stop with no start leaves result
    set_mode(2'b00);
    run_pat(-1, -1, -1, -1, 2, -1);
    rd_chk(1, 11, "R10 lone stop");

    // R6 falling edges ignored: IA high first, VA rises, IA falls, IA rises
    i_pos[0] = 1'b1; idle(3);
    rd_chk(0, 6, "R10 stop while idle");
    v_pos[0] = 1'b1; idle(5);
    i_pos[0] = 1'b0; idle(2);
    v_pos[0] = 1'b0; idle(2);
    i_pos[0] = 1'b1; idle(4);
    rd_chk(0, 9, "R6 falling ignored");
    v_pos = '0; i_pos = '0; idle(3);

    // R8 restart on repeated start
    v_pos[1] = 1'b1; idle(3);
    v_pos[1] = 1'b0; idle(7);
    v_pos[1] = 1'b1; idle(15);
    i_pos[1] = 1'b1; idle(4);
    rd_chk(1, 15, "R8 restart");
    v_pos = '0; i_pos = '0; idle(3);

    // R9 pairing change aborts, results kept
    rd_addr = 2'd0; idle(1);
    r0 = int'(rd_data);
    v_pos[0] = 1'b1; idle(5);
    pair_sel = 2'b01; idle(5);
    rd_chk(0, r0, "R9 kept after change");
    pair_sel = 2'b00; idle(5);
    i_pos[0] = 1'b1; idle(4);
    rd_chk(0, r0, "R9 aborted channel");
    v_pos = '0; i_pos = '0; idle(3);

    // R7 saturation boundary and overflow
    run_pat(-1, -1, 0, -1, -1, 65535);
    rd_chk(2, 65535, "R7 max delay");
    run_pat(-1, -1, 0, -1, -1, 66000);
    rd_chk(2, 65535, "R7 saturate");

    // R11 read latency: address change shows after one edge
    rd_addr = 2'd1; @(negedge clk);
    rd_addr = 2'd3; @(negedge clk);
    chk("R11 addr 3 after 1", int'(rd_data), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule